// File: doc/BRIEF.md
# Three-Wire Host Command and Status Port

This block is a slave serial port that lets a host controller talk to the chip over three lines: a serial clock, a load/direction line and a data line. The data pad itself is outside the block. The block takes the incoming data level and returns an outgoing level together with an output enable. With the load line high, the host shifts one byte into an 8-bit command register. Dropping the load line commits that byte. With the load line already low, the host clocks an 8-bit status snapshot out of the port instead.

Two command bits act as one-shot requests and clear themselves one system clock after they are written. The other six bits hold their value until the next write. When a status read finishes, the port issues a one-cycle clear strobe for the three sticky status flags, so the logic that holds those flags can drop them. All three host lines cross into the system clock domain through flop chains. Every decision is made on edges seen in that domain.

Top module: `hostport`

## Requirements
- R1: While `host_load` is high, each rising edge of `host_clk` shifts in one bit of `host_din`, most significant bit first. A falling `host_load` then commits the byte to `cmd_out`.
- R2: A byte is committed only if at least 8 bits were shifted in since the port was last idle. When more than 8 bits arrive, the last 8 are kept. With 1 to 7 bits, `cmd_out` keeps its value and no read starts.
- R3: Bit 7 (flush request) and bit 0 (position-found request) of `cmd_out` each read 1 for exactly one system clock after a commit that sets them, and 0 after that.
- R4: Bits 6 down to 1 of `cmd_out` hold their committed value until the next commit. A status read does not alter them.
- R5: After reset, `cmd_out` is 8'h40, so only the bypass bit (bit 6) is set. At the same time `host_doe` is 0 and `sticky_clr` is 8'h00.
- R6: A falling `host_load` with no bits shifted since idle starts a read. Bit 7 of the status snapshot appears on `host_dout` at once. Each rising `host_clk` edge then moves to the next lower bit.
- R7: The status byte is captured when the read starts. Later changes of `status_in` during that read do not appear on `host_dout`.
- R8: `host_doe` is 1 only during a read while `host_load` is low. It is 0 while idle and throughout a write sequence.
- R9: A rising `host_load` that ends a read drives `sticky_clr` to 8'h38 for exactly one system clock. This marks framing error (bit 5), new frame (bit 4) and full (bit 3). Ending a write produces no strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_clk | input | 1 | Host serial clock, asynchronous |
| host_load | input | 1 | Host load/direction line, asynchronous |
| host_din | input | 1 | Level from the data pad |
| host_dout | output | 1 | Level to drive onto the data pad |
| host_doe | output | 1 | Enable for the data pad driver |
| status_in | input | 8 | Live status byte from the status logic |
| cmd_out | output | 8 | Command register |
| sticky_clr | output | 8 | One-cycle clear mask for the sticky status flags |

## Verification
The hardest states to reach from the ports are the malformed host sequences: a write cut short after a few bits, a write that runs past eight bits, and a status byte that changes while it is being shifted out. The stimulus reaches them through a host-sequence task. That task takes an arbitrary bit count, and changes `status_in` in the middle of a read. The one-cycle command pulses and the clear strobe are watched on every system clock after the relevant load-line edge, so both their width and their presence are counted.

// File: rtl/hostport_pkg.sv
package hostport_pkg;
  localparam int BYTE_W = 8;

  // command bit positions
  localparam int CMD_FLUSH  = 7;
  localparam int CMD_BYPASS = 6;
  localparam int CMD_POSFND = 0;

  localparam logic [BYTE_W-1:0] CMD_RESET_VAL = 8'h40;
  localparam logic [BYTE_W-1:0] CMD_AUTO_MASK = 8'h81;
  localparam logic [BYTE_W-1:0] STICKY_MASK   = 8'h38;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_READ = 2'd1,
    ST_HOLD = 2'd2
  } port_state_t;
endpackage

// File: rtl/hostport_sync.sv
module hostport_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] d_sync
);
  logic [STAGES-1:0][W-1:0] stg_q;
  logic [STAGES-1:0][W-1:0] stg_n;

  always_comb begin
    stg_n[0] = d_async;
    for (int i = 1; i < STAGES; i++) stg_n[i] = stg_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
    end else begin
      stg_q <= stg_n;
    end
  end

  assign d_sync = stg_q[STAGES-1];
endmodule

// File: rtl/hostport_engine.sv
module hostport_engine
  import hostport_pkg::*;
#(
  parameter int DW = BYTE_W,
  localparam int CW = $clog2(DW + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hclk_s,
  input  logic          hload_s,
  input  logic          hdin_s,
  input  logic [DW-1:0] stat_in,
  output logic          dout,
  output logic          doe,
  output logic          wr_stb,
  output logic [DW-1:0] wr_byte,
  output logic [DW-1:0] clr_mask
);
  port_state_t   st_q, st_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic [DW-1:0] sh_q, sh_n;
  logic [DW-1:0] clr_q, clr_n;
  logic          hclk_q, hload_q;
  logic          hclk_rise, load_fall, load_rise;

  assign hclk_rise = hclk_s & ~hclk_q;
  assign load_fall = ~hload_s & hload_q;
  assign load_rise = hload_s & ~hload_q;

  always_comb begin
    st_n   = st_q;
    cnt_n  = cnt_q;
    sh_n   = sh_q;
    clr_n  = '0;
    wr_stb = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (load_fall) begin
          cnt_n = '0;
          if (cnt_q == CW'(DW)) begin
            wr_stb = 1'b1;
            st_n   = ST_HOLD;
          end else if (cnt_q == '0) begin
            sh_n = stat_in;
            st_n = ST_READ;
          end else begin
            st_n = ST_HOLD;
          end
        end else if (hload_s && hclk_rise) begin
          sh_n = {sh_q[DW-2:0], hdin_s};
          if (cnt_q != CW'(DW)) cnt_n = cnt_q + 1'b1;
        end
      end
      ST_READ: begin
        if (load_rise) begin
          clr_n = STICKY_MASK;
          st_n  = ST_IDLE;
        end else if (hclk_rise) begin
          sh_n = {sh_q[DW-2:0], 1'b0};
        end
      end
      default: begin
        if (load_rise) st_n = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      clr_q   <= '0;
      hclk_q  <= 1'b1;
      hload_q <= 1'b1;
    end else begin
      st_q    <= st_n;
      cnt_q   <= cnt_n;
      sh_q    <= sh_n;
      clr_q   <= clr_n;
      hclk_q  <= hclk_s;
      hload_q <= hload_s;
    end
  end

  assign wr_byte  = sh_q;
  assign dout     = sh_q[DW-1];
  assign doe      = (st_q == ST_READ) && !hload_s;
  assign clr_mask = clr_q;

  // R9
  clr_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr_q) |-> $past(st_q == ST_READ));
  // R9
  clr_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr_q) |=> (clr_q == '0));
  // R8
  oe_only_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (doe && $past(doe)) |-> $past(st_q == ST_READ));
endmodule

// File: rtl/hostport_cmdreg.sv
module hostport_cmdreg
  import hostport_pkg::*;
#(
  parameter int DW = BYTE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_stb,
  input  logic [DW-1:0] wr_byte,
  output logic [DW-1:0] cmd_q
);
  logic [DW-1:0] cmd_n;

  always_comb begin
    if (wr_stb) cmd_n = wr_byte;
    else        cmd_n = cmd_q & ~CMD_AUTO_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmd_q <= CMD_RESET_VAL;
    else        cmd_q <= cmd_n;
  end

  // R3
  flush_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_q[CMD_FLUSH] |=> !cmd_q[CMD_FLUSH]);
  // R3
  posfnd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_q[CMD_POSFND] |=> !cmd_q[CMD_POSFND]);
  // R4
  bypass_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |=> $stable(cmd_q[CMD_BYPASS]));
endmodule

// File: rtl/hostport.sv
module hostport
  import hostport_pkg::*;
#(
  parameter int DW = BYTE_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_clk,
  input  logic          host_load,
  input  logic          host_din,
  output logic          host_dout,
  output logic          host_doe,
  input  logic [DW-1:0] status_in,
  output logic [DW-1:0] cmd_out,
  output logic [DW-1:0] sticky_clr
);
  logic [2:0]    lines_s;
  logic          wr_stb;
  logic [DW-1:0] wr_byte;

  // line order: {din, load, clk}; clock and load rest high
  hostport_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b011)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async ({host_din, host_load, host_clk}),
    .d_sync  (lines_s)
  );

  hostport_engine #(.DW(DW)) u_eng (
    .clk      (clk),
    .rst_n    (rst_n),
    .hclk_s   (lines_s[0]),
    .hload_s  (lines_s[1]),
    .hdin_s   (lines_s[2]),
    .stat_in  (status_in),
    .dout     (host_dout),
    .doe      (host_doe),
    .wr_stb   (wr_stb),
    .wr_byte  (wr_byte),
    .clr_mask (sticky_clr)
  );

  hostport_cmdreg #(.DW(DW)) u_cmd (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_stb  (wr_stb),
    .wr_byte (wr_byte),
    .cmd_q   (cmd_out)
  );
endmodule

// File: tb/hostport_test.sv
module hostport_test;
  localparam int H = 6;
  localparam int NV = 6;
  // {command byte, status byte}
  localparam logic [15:0] VEC [NV] = '{
    16'hA5_3C, 16'h81_FF, 16'h7E_00, 16'h00_A5, 16'hFF_5A, 16'h14_81
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_clk = 1'b1, host_load = 1'b1, host_din = 1'b0;
  logic host_dout, host_doe;
  logic [7:0] status_in = 8'h00;
  logic [7:0] cmd_out, sticky_clr;

  int n_chk = 0, n_bad = 0;
  int flush_cnt, pf_cnt, clr_cnt, clr_any;
  logic doe_seen;
  logic [7:0] rd_byte;

  always #2 clk = ~clk;

  hostport uut (
    .clk(clk), .rst_n(rst_n), .host_clk(host_clk), .host_load(host_load),
    .host_din(host_din), .host_dout(host_dout), .host_doe(host_doe),
    .status_in(status_in), .cmd_out(cmd_out), .sticky_clr(sticky_clr)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // watch the one-cycle outputs on every system clock for n cycles
  task automatic watch(input int n);
    flush_cnt = 0; pf_cnt = 0; clr_cnt = 0; clr_any = 0; doe_seen = 1'b0;
    for (int i = 0; i < n; i++) begin
      tick(1);
      if (cmd_out[7]) flush_cnt++;
      if (cmd_out[0]) pf_cnt++;
      if (sticky_clr == 8'h38) clr_cnt++;
      if (sticky_clr != 8'h00) clr_any++;
      if (host_doe) doe_seen = 1'b1;
    end
  endtask

  task automatic host_write(input logic [15:0] data, input int nbits);
    for (int b = nbits - 1; b >= 0; b--) begin
      host_clk = 1'b0; host_din = data[b];
      tick(H);
      if (host_doe) doe_seen = 1'b1;
      host_clk = 1'b1;
      tick(H);
    end
    host_load = 1'b0;
    watch(2 * H);
  endtask

  task automatic host_end();
    host_load = 1'b1;
    watch(2 * H);
  endtask

  task automatic host_read(input logic [7:0] flip_after, input logic flip);
    logic d;
    host_load = 1'b0;
    tick(2 * H);
    check("R8 oe during read", {7'd0, host_doe}, 8'h01);
    for (int b = 7; b >= 0; b--) begin
      d = host_dout;
      rd_byte[b] = d;
      if (flip && b == 5) status_in = ~status_in;
      host_clk = 1'b0;
      tick(H);
      host_clk = 1'b1;
      tick(H);
    end
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    tick(5);
    // R5 reset state
    check("R5 cmd after reset", cmd_out, 8'h40);
    check("R5 oe after reset", {7'd0, host_doe}, 8'h00);
    check("R5 clear after reset", sticky_clr, 8'h00);
    rst_n = 1'b1;
    tick(H);

    for (int v = 0; v < NV; v++) begin
      doe_seen = 1'b0;
      host_write({8'h00, VEC[v][15:8]}, 8);
      check("R1 committed byte", cmd_out, VEC[v][15:8] & 8'h7E);
      check("R3 flush pulse width", 8'(flush_cnt), {7'd0, VEC[v][15]});
      check("R3 posfound pulse width", 8'(pf_cnt), {7'd0, VEC[v][8]});
      check("R8 no oe in write", {7'd0, doe_seen}, 8'h00);
      host_end();
      check("R9 no strobe after write", 8'(clr_any), 8'h00);
      status_in = VEC[v][7:0];
      host_read(8'h00, 1'b0);
      check("R6 status shifted out", rd_byte, VEC[v][7:0]);
      host_end();
      check("R9 strobe once after read", 8'(clr_cnt), 8'h01);
      check("R9 strobe no other value", 8'(clr_any), 8'h01);
      check("R8 oe off after read", {7'd0, host_doe}, 8'h00);
      check("R4 cmd unchanged by read", cmd_out, VEC[v][15:8] & 8'h7E);
    end

    // R7: status changes mid-read
    status_in = 8'hC3;
    host_read(8'h00, 1'b1);
    check("R7 snapshot held", rd_byte, 8'hC3);
    host_end();

    // R2: short write ignored, no read starts
    host_write({8'h00, 8'h42}, 8);
    host_end();
    doe_seen = 1'b0;
    host_write(16'h00FF, 5);
    check("R2 short write ignored", cmd_out, 8'h42);
    check("R2 short write no read", {7'd0, doe_seen}, 8'h00);
    host_end();
    check("R2 short write no strobe", 8'(clr_any), 8'h00);

    // R2: overlong write keeps last 8 bits
    host_write(16'h0326, 10);
    check("R2 last eight bits kept", cmd_out, 8'h26);
    host_end();

    // R5: reset mid-run
    host_write({8'h00, 8'h3E}, 8);
    host_end();
    rst_n = 1'b0;
    tick(5);
    check("R5 cmd after second reset", cmd_out, 8'h40);
    rst_n = 1'b1;
    tick(H);
    check("R5 cmd after release", cmd_out, 8'h40);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule